// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives software access to two internal lookup tables through one small register aperture instead of a flat map. The first is a scheme table of 32 entries, each 24 words wide. The second is a per-port table of 64 entries, each holding a scheme-partition word and a classification-plan-partition word. Software loads the operand words into a staging window, then writes a single action word. That word names the table, the entry, the direction, and, for ports, which of the two words to touch.

A sequencer holds the action busy for a fixed number of cycles. At the end it either copies the staging words into the entry or copies the entry into the staging words. It then clears the busy flag. Software polls the action word until the busy flag drops, then reads the error flag. Requests that name a missing entry or an undefined table are flagged and leave every table and the staging window untouched.

Top module: `indirect_table_ctrl`

## Requirements
- R1: After reset every table entry, every staging word and the action word read as zero.
- R2: The staging window is 63 words at byte addresses 0x100 + 4k (k = 0..62), and each word reads back the last value loaded into it. The action word is at byte address 0x1FC. Every other address reads zero and ignores writes.
- R3: Writing the action word with bit 31 (GO) set, while idle, makes bit 31 read 1 for exactly LAT cycles (default 4), after which it reads 0. An action write with bit 31 clear has no effect.
- R4: While GO reads 1, writes to the action word and to the staging window are ignored.
- R5: Action bits 25:24 select the table: 00 selects the scheme table and 10 selects the port table. Bits 23:16 carry the scheme index and bits 7:0 carry the port index. Scheme indices 0..31 and port indices 0..63 are all reachable.
- R6: A scheme write (bit 30 = 0) copies staging words 0..23 into the entry. Staging word 16 is the packet counter and is copied only when bit 15 is set; otherwise the stored counter is kept.
- R7: A scheme read (bit 30 = 1) loads all 24 entry words into staging words 0..23 and leaves staging words 24..62 unchanged.
- R8: A port access moves the scheme-partition word to or from staging word 0 when bit 15 is set, and the classification-plan word to or from staging word 1 when bit 14 is set. A word that is not selected stays unchanged, both in the table and in the staging window.
- R9: An action with scheme index ≥ 32, port index ≥ 64, or select 01 or 11 sets bit 29 (error) at completion and changes neither the tables nor the staging window. A valid action clears bit 29.
- R10: Bits 30, 28:0 of the action word read back the last accepted action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench targets the counter word of a scheme entry. A design that always writes it would lose the count when bit 15 is clear, and one that never writes it would not reload the count. Port accesses with only one select bit expose a design that updates both words or loads staging words that were not asked for. The bench also probes the first illegal scheme and port indices (32, 64) and the undefined selects. A design with wrong bounds would corrupt an entry or drop a legal one. Action and staging writes made while the block is busy check that a late write neither restarts the transfer nor leaks into its data.

// File: rtl/itac_pkg.sv
`timescale 1ns/1ps
package itac_pkg;
  localparam int ACT_GO   = 31;
  localparam int ACT_RD   = 30;
  localparam int ACT_ERR  = 29;
  localparam int ACT_SELA = 15;  // scheme: update counter, port: partition word
  localparam int ACT_SELB = 14;  // port: classification-plan word

  typedef enum logic [1:0] {
    TBL_SCHEME = 2'b00,
    TBL_RSVD1  = 2'b01,
    TBL_PORT   = 2'b10,
    TBL_RSVD3  = 2'b11
  } tbl_sel_e;

  function automatic tbl_sel_e act_table(input logic [31:0] w);
    return tbl_sel_e'(w[25:24]);
  endfunction

  function automatic logic [7:0] act_sch_idx(input logic [31:0] w);
    return w[23:16];
  endfunction

  function automatic logic [7:0] act_port_idx(input logic [31:0] w);
    return w[7:0];
  endfunction

  function automatic logic act_bad(input logic [31:0] w, input int sch_n, input int port_n);
    case (act_table(w))
      TBL_SCHEME: return 32'(act_sch_idx(w)) >= 32'(sch_n);
      TBL_PORT:   return 32'(act_port_idx(w)) >= 32'(port_n);
      default:    return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/itac_seq.sv
`timescale 1ns/1ps
module itac_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start && !busy) cnt_q <= CW'(LAT);
    else if (busy)          cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/itac_tables.sv
`timescale 1ns/1ps
module itac_tables
  import itac_pkg::*;
#(
  parameter int SCH_N     = 32,
  parameter int PORT_N    = 64,
  parameter int SCH_WORDS = 24,
  parameter int CNT_WORD  = 16,
  parameter int WIN_WORDS = 63
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [31:0]          cmd,
  input  logic [31:0]          stage   [WIN_WORDS],
  output logic [WIN_WORDS-1:0] ld_mask,
  output logic [31:0]          ld_data [WIN_WORDS]
);
  localparam int SI_W = $clog2(SCH_N);
  localparam int PI_W = $clog2(PORT_N);

  logic [31:0] sch_mem [SCH_N][SCH_WORDS];
  logic [31:0] sp_mem  [PORT_N];
  logic [31:0] cpp_mem [PORT_N];

  logic [7:0]      si_full, pi_full;
  logic [SI_W-1:0] si;
  logic [PI_W-1:0] pi;
  logic            is_sch, is_port, do_wr;

  assign si_full = act_sch_idx(cmd);
  assign pi_full = act_port_idx(cmd);
  assign si      = si_full[SI_W-1:0];
  assign pi      = pi_full[PI_W-1:0];
  assign is_sch  = (act_table(cmd) == TBL_SCHEME);
  assign is_port = (act_table(cmd) == TBL_PORT);
  assign do_wr   = commit && !cmd[ACT_RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < SCH_N; e++)
        for (int w = 0; w < SCH_WORDS; w++) sch_mem[e][w] <= '0;
      for (int p = 0; p < PORT_N; p++) begin
        sp_mem[p]  <= '0;
        cpp_mem[p] <= '0;
      end
    end else if (do_wr && is_sch) begin
      for (int w = 0; w < SCH_WORDS; w++)
        if (w != CNT_WORD || cmd[ACT_SELA]) sch_mem[si][w] <= stage[w];
    end else if (do_wr && is_port) begin
      if (cmd[ACT_SELA]) sp_mem[pi]  <= stage[0];
      if (cmd[ACT_SELB]) cpp_mem[pi] <= stage[1];
    end
  end

  always_comb begin
    ld_mask = '0;
    for (int k = 0; k < WIN_WORDS; k++) ld_data[k] = '0;
    if (is_sch) begin
      for (int w = 0; w < SCH_WORDS; w++) begin
        ld_mask[w] = 1'b1;
        ld_data[w] = sch_mem[si][w];
      end
    end else if (is_port) begin
      ld_mask[0] = cmd[ACT_SELA];
      ld_data[0] = sp_mem[pi];
      ld_mask[1] = cmd[ACT_SELB];
      ld_data[1] = cpp_mem[pi];
    end
  end
endmodule

// File: rtl/indirect_table_ctrl.sv
`timescale 1ns/1ps
module indirect_table_ctrl
  import itac_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SCH_N     = 32,
  parameter int PORT_N    = 64,
  parameter int SCH_WORDS = 24,
  parameter int CNT_WORD  = 16,
  parameter int WIN_WORDS = 63,
  parameter int LAT       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int WA_W     = ADDR_W - 2;
  localparam int ACT_WORD = (1 << WA_W) - 1;
  localparam int WIN_BASE = ACT_WORD - WIN_WORDS;
  localparam int IW       = $clog2(WIN_WORDS);

  logic [WA_W-1:0] waddr;
  logic [WA_W-1:0] woff;
  logic [IW-1:0]   win_idx;
  logic            hit_act, hit_win;

  assign waddr   = bus_addr[ADDR_W-1:2];
  assign woff    = waddr - WA_W'(WIN_BASE);
  assign win_idx = woff[IW-1:0];
  assign hit_act = (waddr == WA_W'(ACT_WORD));
  assign hit_win = (waddr >= WA_W'(WIN_BASE)) && (waddr < WA_W'(ACT_WORD));

  // internal events, named for the checker
  logic go_start, seq_busy, seq_done, cmd_bad, commit;
  logic [31:0] cmd_q;
  logic        err_q;
  logic [31:0] stage_q [WIN_WORDS];
  logic [WIN_WORDS-1:0] ld_mask;
  logic [31:0] ld_data [WIN_WORDS];

  assign go_start = bus_wr && hit_act && bus_wdata[ACT_GO] && !seq_busy;
  assign cmd_bad  = act_bad(cmd_q, SCH_N, PORT_N);
  assign commit   = seq_done && !cmd_bad;

  itac_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go_start), .busy(seq_busy), .done(seq_done)
  );

  itac_tables #(
    .SCH_N(SCH_N), .PORT_N(PORT_N), .SCH_WORDS(SCH_WORDS),
    .CNT_WORD(CNT_WORD), .WIN_WORDS(WIN_WORDS)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd_q),
    .stage(stage_q), .ld_mask(ld_mask), .ld_data(ld_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      err_q <= 1'b0;
    end else if (go_start) begin
      cmd_q <= bus_wdata;
      err_q <= 1'b0;
    end else if (seq_done) begin
      err_q <= cmd_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_WORDS; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < WIN_WORDS; i++) begin
        if (commit && cmd_q[ACT_RD] && ld_mask[i])
          stage_q[i] <= ld_data[i];
        else if (bus_wr && hit_win && !seq_busy && win_idx == IW'(i))
          stage_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    if (hit_act)
      bus_rdata = {seq_busy, cmd_q[ACT_RD], err_q, cmd_q[28:0]};
    else if (hit_win)
      bus_rdata = stage_q[win_idx];
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/itac_chk.sv
`timescale 1ns/1ps
module itac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        bad,
  input logic        act_err,
  input logic [31:0] stage0
);
  // R3
  go_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R3
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R4
  stage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(stage0));
  // R9
  err_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad) |=> act_err);
  // R9
  err_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad) |=> !act_err);
  // R9
  bad_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad) |=> $stable(stage0));
endmodule

bind indirect_table_ctrl itac_chk u_itac_chk (
  .clk(clk), .rst_n(rst_n), .start(go_start), .busy(seq_busy), .done(seq_done),
  .bad(cmd_bad), .act_err(err_q), .stage0(stage_q[0])
);

// File: tb/test_indirect_table_ctrl.sv
`timescale 1ns/1ps
module test_indirect_table_ctrl;
  localparam int LAT = 4;
  localparam logic [8:0] ACT = 9'h1FC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  indirect_table_ctrl i_indirect_table_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {action word, expected error}
  localparam logic [32:0] VEC [9] = '{
    {32'h8000_8000, 1'b0},   // scheme 0 write
    {32'hC01F_0000, 1'b0},   // scheme 31 read
    {32'h8020_0000, 1'b1},   // scheme 32
    {32'hC0FF_0000, 1'b1},   // scheme 255
    {32'hC200_803F, 1'b0},   // port 63 read
    {32'h8200_8040, 1'b1},   // port 64
    {32'h8100_0003, 1'b1},   // select 01
    {32'hC300_0003, 1'b1},   // select 11
    {32'h8200_0000, 1'b0}    // port 0, no word selected
  };

  function automatic logic [31:0] pat(input int k);
    return 32'hC0DE_0000 + 32'(k) * 32'h0001_0003;
  endfunction

  function automatic logic [8:0] wa(input int k);
    return 9'(32'h100 + 4 * k);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  // write an action, return number of cycles GO stayed set
  task automatic run(input logic [31:0] act_w, output int cyc);
    logic [31:0] v;
    wr(ACT, act_w);
    cyc = 0;
    peek(ACT, v);
    while (v[31] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      peek(ACT, v);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ACT, v);        chk("R1 action", v, 32'h0);
    rd(wa(0), v);      chk("R1 stage0", v, 32'h0);
    rd(wa(62), v);     chk("R1 stage62", v, 32'h0);
    rd(9'h000, v);     chk("R2 outside", v, 32'h0);

    // vector table: R3 timing, R5/R9 error, R10 echo
    for (int t = 0; t < 9; t++) begin
      run(VEC[t][32:1], cyc);
      chk("R3 busy cycles", 32'(cyc), 32'(LAT));
      rd(ACT, v);
      chk("R9 error flag", 32'(v[29]), 32'(VEC[t][0]));
      chk("R10 echo", v & 32'h5FFF_FFFF, VEC[t][32:1] & 32'h5FFF_FFFF);
    end

    // R2 staging window readback
    for (int k = 0; k < 63; k++) wr(wa(k), pat(k));
    for (int k = 0; k < 63; k++) begin
      rd(wa(k), v);
      chk("R2 window", v, pat(k));
    end

    // R6/R7 scheme write with counter, then read back
    run(32'h8009_8000, cyc);
    for (int k = 0; k < 24; k++) wr(wa(k), 32'hDEAD_0000 | 32'(k));
    run(32'hC009_0000, cyc);
    for (int k = 0; k < 24; k++) begin
      rd(wa(k), v);
      chk("R7 scheme read", v, pat(k));
    end
    rd(wa(40), v);     chk("R7 upper window kept", v, pat(40));

    // R6 write without counter update keeps stored counter
    for (int k = 0; k < 24; k++) wr(wa(k), ~pat(k));
    run(32'h8009_0000, cyc);
    for (int k = 0; k < 24; k++) wr(wa(k), 32'h0);
    run(32'hC009_0000, cyc);
    rd(wa(16), v);     chk("R6 counter kept", v, pat(16));
    rd(wa(3), v);      chk("R6 word written", v, ~pat(3));

    // R5 last scheme index
    wr(wa(0), 32'h3131_3131);
    run(32'h801F_8000, cyc);
    wr(wa(0), 32'h0);
    run(32'hC01F_0000, cyc);
    rd(wa(0), v);      chk("R5 scheme 31", v, 32'h3131_3131);

    // R8 port word selection
    wr(wa(0), 32'h1111_0000); wr(wa(1), 32'h2222_0000);
    run(32'h8200_803F, cyc);
    wr(wa(0), 32'h0); wr(wa(1), 32'h0);
    run(32'hC200_C03F, cyc);
    rd(wa(0), v);      chk("R8 partition word", v, 32'h1111_0000);
    rd(wa(1), v);      chk("R8 plan word untouched", v, 32'h0);
    wr(wa(1), 32'h3333_0000); wr(wa(0), 32'h0);
    run(32'h8200_403F, cyc);
    wr(wa(0), 32'h77); wr(wa(1), 32'h0);
    run(32'hC200_403F, cyc);
    rd(wa(0), v);      chk("R8 unselected staging", v, 32'h77);
    rd(wa(1), v);      chk("R8 plan word", v, 32'h3333_0000);

    // R9 rejected actions change nothing
    wr(wa(0), 32'h0BAD_0BAD);
    run(32'h8200_8040, cyc);
    run(32'h8100_803F, cyc);
    run(32'hC200_8040, cyc);
    rd(wa(0), v);      chk("R9 staging kept", v, 32'h0BAD_0BAD);
    run(32'hC200_803F, cyc);
    rd(wa(0), v);      chk("R9 table kept", v, 32'h1111_0000);

    // R4 writes during busy are ignored
    wr(ACT, 32'hC009_0000);
    wr(ACT, 32'h8200_8040);
    wr(wa(30), 32'hFFFF_FFFF);
    repeat (LAT + 2) @(negedge clk);
    rd(ACT, v);        chk("R4 action kept", v, 32'h4009_0000);
    rd(wa(30), v);     chk("R4 staging kept", v, pat(30));
    rd(wa(16), v);     chk("R4 transfer done", v, pat(16));

    // R3 action write without GO
    wr(ACT, 32'h0200_0005);
    peek(ACT, v);      chk("R3 no GO no start", v, 32'h4009_0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule